// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the register-programming front end of an eight-line interrupt controller. Software reaches it through two byte-wide ports, selected by `port_sel`. A port-0 write is decoded as one of three things. It may start the initialization sequence. It may be a read-control command, which sets register select, poll and special mask. Or it may be an operation command, which covers the end-of-interrupt variants and priority rotation. A port-1 write either feeds the next initialization word or, in normal operation, loads the mask register.

The sequencer exports its programmed state to a separate resolver core. That state is the mask, the vector base, the auto-EOI and nested-mode flags, the rotate-on-auto-EOI flag, special mask and the priority rotation offset. It also sends one-cycle clear pulses for in-service and request bits, plus a flush pulse when initialization starts. The resolver core sends back its request and in-service registers and its current pending line, which the sequencer uses for reads, for poll and for non-specific end-of-interrupt. Read data is registered and valid in the cycle after `rd_en`.

Top module: `intc_cmd_seq`

## Requirements
- R1: After reset every output is zero, the sequencer is in normal operation (`init_busy` = 0), poll is disarmed and reads of port 0 return the request register.
- R2: A port-0 write with bit 4 set pulses `init_flush` for one cycle. It clears the mask, vector base, offset and every mode, select and poll flag. It raises `init_busy` and stores bit 0 as the fourth-word flag.
- R3: The first port-1 write after an initialization start loads `vec_base` with the data with its low three bits forced to zero.
- R4: The second port-1 write moves on to a third word if the fourth-word flag was set. Otherwise it ends initialization (`init_busy` drops).
- R5: The third port-1 word sets `nested_mode` from bit 4 and `auto_eoi` from bit 1, and ends initialization.
- R6: In normal operation a port-1 write loads `mask_reg` with the full byte.
- R7: A port-0 write with bit 4 clear and bit 3 set is read control. Bit 2 arms poll. When bit 1 is set, bit 0 selects in-service (1) or request (0) for port-0 reads. When bit 6 is set, bit 5 becomes `special_mask`.
- R8: Other port-0 writes carry a command in bits 7:5. Command 0 clears and command 4 sets `rot_on_aeoi`. Command 2 changes nothing.
- R9: Command 1 clears the in-service bit of highest priority: the first set line found scanning from `prio_ofs` upward modulo 8. Command 5 also sets `prio_ofs` to that line plus one. With an empty in-service register neither command has any effect.
- R10: Command 3 clears in-service line `wdata[2:0]`. Command 7 does the same and sets `prio_ofs` to that line plus one. Command 6 sets `prio_ofs` to (`wdata[2:0]`+1) mod 8.
- R11: A read while poll is armed returns the pending line in bits 2:0 and pulses both `isr_clear` and `req_clear` for that line. With nothing pending it returns 7 and pulses no clear. Poll disarms after that single read.
- R12: A non-poll port-0 read returns `core_isr` or `core_req` according to the select flag. A port-1 read returns `mask_reg`.
- R13: `isr_clear`, `req_clear` and `init_flush` are single-cycle pulses that appear only in the cycle after a write or read that causes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| port_sel | input | 1 | Port address (0 or 1) |
| wdata | input | 8 | Write data |
| core_req | input | 8 | Request register from resolver core |
| core_isr | input | 8 | In-service register from resolver core |
| pend_valid | input | 1 | Resolver core has a line to deliver |
| pend_line | input | 3 | Line the resolver core would deliver |
| rdata | output | 8 | Registered read data |
| mask_reg | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| nested_mode | output | 1 | Special fully nested mode |
| rot_on_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| prio_ofs | output | 3 | Priority rotation offset (lowest-number line) |
| isr_clear | output | 8 | One-cycle in-service clear pulse per line |
| req_clear | output | 8 | One-cycle request clear pulse per line |
| init_flush | output | 1 | One-cycle pulse clearing the core at init start |
| init_busy | output | 1 | Initialization sequence in progress |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that `core_isr` and `pend_line` are stable while a command that uses them is being decoded. The bench follows both rules: it issues exactly one access per two-cycle slot, and it changes the resolver-side inputs only between accesses. Under those assumptions, a clear pulse always traces back to the access one cycle earlier and never marks more than one line.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;

    localparam int LINES  = 8;
    localparam int LINE_W = $clog2(LINES);
    localparam int DATA_W = 8;

    // command field positions inside a port-0 byte
    localparam int B_INIT  = 4;
    localparam int B_RDCTL = 3;
    localparam int CMD_LSB = 5;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_BASE  = 2'd1,
        ST_WORD3 = 2'd2,
        ST_WORD4 = 2'd3
    } init_step_e;

    typedef enum logic [2:0] {
        OP_ROT_OFF  = 3'd0,
        OP_EOI_NS   = 3'd1,
        OP_NOP      = 3'd2,
        OP_EOI_SP   = 3'd3,
        OP_ROT_ON   = 3'd4,
        OP_EOI_NSR  = 3'd5,
        OP_SET_PRIO = 3'd6,
        OP_EOI_SPR  = 3'd7
    } op_code_e;

    typedef struct packed {
        logic              found;
        logic [LINE_W-1:0] line;
    } line_pick_t;

    typedef struct packed {
        logic poll_arm;
        logic isr_sel;
        logic smask;
    } rd_ctl_t;

    function automatic logic [LINES-1:0] line_bit(input logic [LINE_W-1:0] l);
        logic [LINES-1:0] v;
        v = '0;
        v[l] = 1'b1;
        return v;
    endfunction

    // scan from offset upward, first set bit wins
    function automatic line_pick_t top_line(input logic [LINES-1:0] vec,
                                            input logic [LINE_W-1:0] ofs);
        line_pick_t r;
        logic [LINE_W-1:0] idx;
        r = '0;
        for (int p = LINES - 1; p >= 0; p--) begin
            idx = ofs + LINE_W'(p);
            if (vec[idx]) begin
                r.found = 1'b1;
                r.line  = idx;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/intc_init_seq.sv
module intc_init_seq
    import intc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              port_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              init_start,
    output logic              busy,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] base_q,
    output logic              aeoi_q,
    output logic              nested_q,
    output logic              flush_q
);

    localparam logic [DATA_W-1:0] BASE_KEEP = ~DATA_W'(LINES - 1);

    init_step_e step_q;
    logic       want4_q;
    logic       p1_wr;

    assign init_start = wr_en && !port_sel && wdata[B_INIT];
    assign p1_wr      = wr_en && port_sel;
    assign busy       = (step_q != ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q   <= ST_RUN;
            want4_q  <= 1'b0;
            mask_q   <= '0;
            base_q   <= '0;
            aeoi_q   <= 1'b0;
            nested_q <= 1'b0;
            flush_q  <= 1'b0;
        end else begin
            flush_q <= init_start;
            if (init_start) begin
                step_q   <= ST_BASE;
                want4_q  <= wdata[0];
                mask_q   <= '0;
                base_q   <= '0;
                aeoi_q   <= 1'b0;
                nested_q <= 1'b0;
            end else if (p1_wr) begin
                unique case (step_q)
                    ST_RUN:   mask_q <= wdata;
                    ST_BASE: begin
                        base_q <= wdata & BASE_KEEP;
                        step_q <= ST_WORD3;
                    end
                    ST_WORD3: step_q <= want4_q ? ST_WORD4 : ST_RUN;
                    ST_WORD4: begin
                        nested_q <= wdata[4];
                        aeoi_q   <= wdata[1];
                        step_q   <= ST_RUN;
                    end
                    default:  step_q <= ST_RUN;
                endcase
            end
        end
    end

endmodule

// File: rtl/intc_op_unit.sv
module intc_op_unit
    import intc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              port_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              init_start,
    input  logic [LINES-1:0]  core_isr,
    input  logic              pend_valid,
    input  logic [LINE_W-1:0] pend_line,
    output rd_ctl_t           ctl_q,
    output logic              rot_q,
    output logic [LINE_W-1:0] ofs_q,
    output logic [LINES-1:0]  isr_clr_q,
    output logic [LINES-1:0]  req_clr_q
);

    logic              p0_wr;
    logic              is_rdctl;
    logic              is_op;
    op_code_e          op;
    line_pick_t        pick;
    logic [LINE_W-1:0] spec_line;
    logic              poll_rd;
    logic [LINES-1:0]  isr_clr_d;
    logic [LINES-1:0]  req_clr_d;
    logic [LINE_W-1:0] ofs_d;
    logic              rot_d;

    assign p0_wr     = wr_en && !port_sel && !wdata[B_INIT];
    assign is_rdctl  = p0_wr && wdata[B_RDCTL];
    assign is_op     = p0_wr && !wdata[B_RDCTL];
    assign op        = op_code_e'(wdata[DATA_W-1:CMD_LSB]);
    assign spec_line = wdata[LINE_W-1:0];
    assign pick      = top_line(core_isr, ofs_q);
    assign poll_rd   = rd_en && ctl_q.poll_arm;

    always_comb begin
        isr_clr_d = '0;
        req_clr_d = '0;
        ofs_d     = ofs_q;
        rot_d     = rot_q;
        if (is_op) begin
            unique case (op)
                OP_ROT_OFF:  rot_d = 1'b0;
                OP_ROT_ON:   rot_d = 1'b1;
                OP_EOI_NS, OP_EOI_NSR: begin
                    if (pick.found) begin
                        isr_clr_d = line_bit(pick.line);
                        if (op == OP_EOI_NSR)
                            ofs_d = pick.line + LINE_W'(1);
                    end
                end
                OP_EOI_SP:   isr_clr_d = line_bit(spec_line);
                OP_EOI_SPR: begin
                    isr_clr_d = line_bit(spec_line);
                    ofs_d     = spec_line + LINE_W'(1);
                end
                OP_SET_PRIO: ofs_d = spec_line + LINE_W'(1);
                default:     ;
            endcase
        end else if (poll_rd && pend_valid) begin
            isr_clr_d = line_bit(pend_line);
            req_clr_d = line_bit(pend_line);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || init_start) begin
            ctl_q     <= '0;
            rot_q     <= 1'b0;
            ofs_q     <= '0;
            isr_clr_q <= '0;
            req_clr_q <= '0;
        end else begin
            rot_q     <= rot_d;
            ofs_q     <= ofs_d;
            isr_clr_q <= isr_clr_d;
            req_clr_q <= req_clr_d;
            if (is_rdctl) begin
                if (wdata[2]) ctl_q.poll_arm <= 1'b1;
                if (wdata[1]) ctl_q.isr_sel  <= wdata[0];
                if (wdata[6]) ctl_q.smask    <= wdata[5];
            end else if (poll_rd) begin
                ctl_q.poll_arm <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/intc_rd_port.sv
module intc_rd_port
    import intc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              port_sel,
    input  rd_ctl_t           ctl,
    input  logic [LINES-1:0]  core_req,
    input  logic [LINES-1:0]  core_isr,
    input  logic [DATA_W-1:0] mask_q,
    input  logic              pend_valid,
    input  logic [LINE_W-1:0] pend_line,
    output logic [DATA_W-1:0] rdata_q
);

    localparam logic [LINE_W-1:0] NO_LINE = LINE_W'(LINES - 1);

    logic [DATA_W-1:0] rd_d;

    always_comb begin
        if (ctl.poll_arm)
            rd_d = DATA_W'(pend_valid ? pend_line : NO_LINE);
        else if (port_sel)
            rd_d = mask_q;
        else if (ctl.isr_sel)
            rd_d = DATA_W'(core_isr);
        else
            rd_d = DATA_W'(core_req);
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_d;
    end

endmodule

// File: rtl/intc_cmd_seq.sv
module intc_cmd_seq
    import intc_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        port_sel,
    input  logic [7:0]  wdata,
    input  logic [7:0]  core_req,
    input  logic [7:0]  core_isr,
    input  logic        pend_valid,
    input  logic [2:0]  pend_line,
    output logic [7:0]  rdata,
    output logic [7:0]  mask_reg,
    output logic [7:0]  vec_base,
    output logic        auto_eoi,
    output logic        nested_mode,
    output logic        rot_on_aeoi,
    output logic        special_mask,
    output logic [2:0]  prio_ofs,
    output logic [7:0]  isr_clear,
    output logic [7:0]  req_clear,
    output logic        init_flush,
    output logic        init_busy
);

    logic    init_start;
    rd_ctl_t ctl;

    intc_init_seq u_init (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .port_sel   (port_sel),
        .wdata      (wdata),
        .init_start (init_start),
        .busy       (init_busy),
        .mask_q     (mask_reg),
        .base_q     (vec_base),
        .aeoi_q     (auto_eoi),
        .nested_q   (nested_mode),
        .flush_q    (init_flush)
    );

    intc_op_unit u_op (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .port_sel   (port_sel),
        .wdata      (wdata),
        .init_start (init_start),
        .core_isr   (core_isr),
        .pend_valid (pend_valid),
        .pend_line  (pend_line),
        .ctl_q      (ctl),
        .rot_q      (rot_on_aeoi),
        .ofs_q      (prio_ofs),
        .isr_clr_q  (isr_clear),
        .req_clr_q  (req_clear)
    );

    assign special_mask = ctl.smask;

    intc_rd_port u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .port_sel   (port_sel),
        .ctl        (ctl),
        .core_req   (core_req),
        .core_isr   (core_isr),
        .mask_q     (mask_reg),
        .pend_valid (pend_valid),
        .pend_line  (pend_line),
        .rdata_q    (rdata)
    );

endmodule

// File: rtl/intc_cmd_seq_chk.sv
module intc_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic       port_sel,
    input logic [7:0] wdata,
    input logic [7:0] mask_reg,
    input logic [7:0] vec_base,
    input logic [7:0] isr_clear,
    input logic [7:0] req_clear,
    input logic       init_flush,
    input logic       init_busy
);

    // R2
    init_start_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !port_sel && wdata[4]) |=> (init_flush && init_busy && mask_reg == 8'h00 && vec_base == 8'h00));

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_sel && !init_busy) |=> (mask_reg == $past(wdata)));

    // R13
    flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
        init_flush |-> $past(wr_en && !port_sel && wdata[4]));

    // R13
    clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (isr_clear != 8'h00) |-> $past(wr_en || rd_en));

    // R9
    single_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(isr_clear));

    // R11
    req_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (req_clear != 8'h00) |-> ($past(rd_en) && isr_clear == req_clear));

endmodule

bind intc_cmd_seq intc_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .port_sel   (port_sel),
    .wdata      (wdata),
    .mask_reg   (mask_reg),
    .vec_base   (vec_base),
    .isr_clear  (isr_clear),
    .req_clear  (req_clear),
    .init_flush (init_flush),
    .init_busy  (init_busy)
);

// File: tb/intc_cmd_seq_test.sv
module intc_cmd_seq_test;

    localparam int CLK_PERIOD = 10;

    // observation selectors
    localparam logic [2:0] O_RD   = 3'd0;
    localparam logic [2:0] O_MASK = 3'd1;
    localparam logic [2:0] O_BASE = 3'd2;
    localparam logic [2:0] O_FLAG = 3'd3;
    localparam logic [2:0] O_OFS  = 3'd4;
    localparam logic [2:0] O_ISRC = 3'd5;

    // {is_read, port, data[7:0], obs[2:0], expected[7:0]}
    localparam int NV = 23;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h11, O_FLAG, 8'h10},  // R2 init with fourth word
        {1'b0, 1'b1, 8'h47, O_BASE, 8'h40},  // R3 base masked
        {1'b0, 1'b1, 8'h00, O_FLAG, 8'h10},  // R4 still busy
        {1'b0, 1'b1, 8'h12, O_FLAG, 8'h03},  // R5 nested+aeoi
        {1'b0, 1'b1, 8'hA5, O_MASK, 8'hA5},  // R6
        {1'b1, 1'b1, 8'h00, O_RD,   8'hA5},  // R12 mask read
        {1'b1, 1'b0, 8'h00, O_RD,   8'h5A},  // R12 request read
        {1'b0, 1'b0, 8'h0B, O_FLAG, 8'h03},  // R7 select isr
        {1'b1, 1'b0, 8'h00, O_RD,   8'h24},  // R12 isr read
        {1'b0, 1'b0, 8'h68, O_FLAG, 8'h0B},  // R7 special mask
        {1'b0, 1'b0, 8'h80, O_FLAG, 8'h0F},  // R8 rotate on
        {1'b0, 1'b0, 8'h20, O_ISRC, 8'h04},  // R9 ns eoi line 2
        {1'b0, 1'b0, 8'hA0, O_OFS,  8'h03},  // R9 rotating ns eoi
        {1'b0, 1'b0, 8'h20, O_ISRC, 8'h20},  // R9 scan from 3 -> line 5
        {1'b0, 1'b0, 8'h66, O_ISRC, 8'h40},  // R10 specific line 6
        {1'b0, 1'b0, 8'hC4, O_OFS,  8'h05},  // R10 set priority
        {1'b0, 1'b0, 8'hE1, O_OFS,  8'h02},  // R10 specific rotate
        {1'b0, 1'b0, 8'hE1, O_ISRC, 8'h02},  // R10 clear line 1
        {1'b0, 1'b0, 8'h40, O_ISRC, 8'h00},  // R8 command 2 no effect
        {1'b0, 1'b0, 8'h0C, O_FLAG, 8'h0F},  // R7 arm poll
        {1'b1, 1'b0, 8'h00, O_RD,   8'h03},  // R11 poll returns line
        {1'b1, 1'b0, 8'h00, O_RD,   8'h24},  // R11 disarmed
        {1'b0, 1'b0, 8'h00, O_FLAG, 8'h0B}   // R8 rotate off
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
    logic [7:0] wdata = '0, core_req = '0, core_isr = '0;
    logic       pend_valid = 1'b0;
    logic [2:0] pend_line = '0;
    logic [7:0] rdata, mask_reg, vec_base, isr_clear, req_clear;
    logic       auto_eoi, nested_mode, rot_on_aeoi, special_mask, init_flush, init_busy;
    logic [2:0] prio_ofs;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intc_cmd_seq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
        .wdata(wdata), .core_req(core_req), .core_isr(core_isr),
        .pend_valid(pend_valid), .pend_line(pend_line), .rdata(rdata),
        .mask_reg(mask_reg), .vec_base(vec_base), .auto_eoi(auto_eoi),
        .nested_mode(nested_mode), .rot_on_aeoi(rot_on_aeoi),
        .special_mask(special_mask), .prio_ofs(prio_ofs), .isr_clear(isr_clear),
        .req_clear(req_clear), .init_flush(init_flush), .init_busy(init_busy)
    );

    function automatic logic [7:0] flags();
        return {3'b000, init_busy, special_mask, rot_on_aeoi, nested_mode, auto_eoi};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one access per two-cycle slot; results sampled at the closing negedge
    task automatic access(input logic is_rd, input logic prt, input logic [7:0] d);
        @(negedge clk);
        wr_en = !is_rd; rd_en = is_rd; port_sel = prt; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    function automatic logic [7:0] observe(input logic [2:0] sel);
        case (sel)
            O_RD:    return rdata;
            O_MASK:  return mask_reg;
            O_BASE:  return vec_base;
            O_FLAG:  return flags();
            O_OFS:   return {5'b0, prio_ofs};
            default: return isr_clear;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 flags", flags(), 8'h00);
        check("R1 mask", mask_reg, 8'h00);
        check("R1 clears", isr_clear | req_clear | {7'b0, init_flush}, 8'h00);
        core_req = 8'h5A; core_isr = 8'h24; pend_valid = 1'b1; pend_line = 3'd3;
        access(1'b1, 1'b0, 8'h00);
        check("R1 read selects request", rdata, 8'h5A);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][20], VEC[i][19], VEC[i][18:11]);
            check($sformatf("vector %0d", i), observe(VEC[i][10:8]), VEC[i][7:0]);
        end

        // R13 pulse lasts one cycle
        access(1'b0, 1'b0, 8'h66);
        check("R13 pulse on", isr_clear, 8'h40);
        @(negedge clk);
        check("R13 pulse off", isr_clear, 8'h00);

        // R9 non-specific eoi with empty in-service: no clear, no offset change
        core_isr = 8'h00;
        access(1'b0, 1'b0, 8'hA0);
        check("R9 empty isr clear", isr_clear, 8'h00);
        check("R9 empty isr offset", {5'b0, prio_ofs}, 8'h02);

        // R11 poll read clears request and in-service of pending line
        access(1'b0, 1'b0, 8'h0C);
        pend_line = 3'd6;
        access(1'b1, 1'b1, 8'h00);
        check("R11 poll line", rdata, 8'h06);
        check("R11 req clear", req_clear, 8'h40);
        check("R11 isr clear", isr_clear, 8'h40);

        // R11 poll with nothing pending
        pend_valid = 1'b0;
        access(1'b0, 1'b0, 8'h0C);
        access(1'b1, 1'b0, 8'h00);
        check("R11 empty poll", rdata, 8'h07);
        check("R11 empty poll clears", isr_clear | req_clear, 8'h00);

        // R2 init clears state; R4 three-word sequence ends without fourth word
        access(1'b0, 1'b0, 8'h10);
        check("R2 flush", {7'b0, init_flush}, 8'h01);
        check("R2 mask cleared", mask_reg, 8'h00);
        check("R2 offset cleared", {5'b0, prio_ofs}, 8'h00);
        check("R2 modes cleared", flags(), 8'h10);
        @(negedge clk);
        check("R13 flush off", {7'b0, init_flush}, 8'h00);
        access(1'b0, 1'b1, 8'hFF);
        check("R3 base", vec_base, 8'hF8);
        access(1'b0, 1'b1, 8'h00);
        check("R4 done", flags(), 8'h00);
        access(1'b0, 1'b1, 8'h3C);
        check("R6 mask after short init", mask_reg, 8'h3C);
        check("R5 third word not taken", flags(), 8'h00);

        // R7 bit1 clear leaves select unchanged, bit6 clear leaves special mask
        access(1'b0, 1'b0, 8'h0B);
        access(1'b0, 1'b0, 8'h29);
        access(1'b1, 1'b0, 8'h00);
        check("R7 select held", rdata, 8'h00);
        check("R7 smask held", flags(), 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule